// File: doc/BRIEF.md
# Cascadable Dual 8-bit Timer/Counter

This block holds two identical 8-bit up-counters. Each one has its own compare value, enable bit, clear-and-start mode bit and match interrupt line. A counter advances once for every rising edge it sees on its count-tick input. The tick input is a level signal that is synchronous to the system clock and is produced by an external prescaler. When a counter becomes equal to its compare value, its interrupt output pulses for one cycle. In clear-and-start mode the counter then returns to zero on its next tick, so it runs through a period of compare+1 ticks.

A cascade bit joins the two counters into one 16-bit counter. Timer 0 is the low byte and timer 1 is the high byte. In this mode, timer 0's tick input, enable bit and mode bit drive the whole 16-bit counter. The two compare registers form one 16-bit compare value, and a 16-bit match pulses both interrupt lines together.

A small register bus writes the compare values and control bits and reads back every register. Reading a count register freezes counting for that cycle, so the byte that is returned is stable. A tick edge that arrives during the read is kept and applied on the next cycle, so no count is lost. In cascade mode the two bytes are read separately, and a carry can occur between the two reads.

Top module: `dual_timer_cascade`

## Requirements
- R1: With the cascade bit clear, an enabled timer increments its count by one on each cycle where its tick input is high after having been low in the previous cycle. In free-run mode (mode bit 0) the count wraps from 255 to 0. A disabled timer does not count.
- R2: While a timer's enable bit (control bit 0) is 0, its count is held at 0. In cascade mode, a 0 in timer 0's enable bit holds both bytes at 0.
- R3: In clear-and-start mode (control bit 1 = 1), a tick that arrives while the count equals the compare value loads 0 instead of incrementing, so the count sequence is 1, 2, …, compare, 0, 1, ….
- R4: A timer's interrupt output is high for exactly the cycle in which a tick has just loaded a count equal to its compare value. Writing a compare value equal to the current count does not raise the interrupt.
- R5: In cascade mode, the counter formed as {count 1, count 0} increments as one 16-bit value on timer 0's ticks. Count 1 changes only when count 0 wraps from 255 to 0. Timer 1's tick input and enable bit are ignored.
- R6: In cascade mode, the 16-bit compare value is {compare 1, compare 0}. A 16-bit match pulses both interrupt outputs in the same cycle. In clear-and-start mode, a tick at a 16-bit match clears both bytes together.
- R7: A read of address 0 or address 1 returns the count as it was before that cycle, and no tick is applied in that cycle. A tick edge seen during the read is applied in the following cycle.
- R8: The register addresses are: 0 = count 0 (read-only), 1 = count 1 (read-only), 2 = compare 0, 3 = compare 1, 4 = control 0, 5 = control 1, 6 = cascade (bit 0). Control bit 0 is enable and bit 1 is clear-and-start. Writes to addresses 0 and 1 are ignored. Read data is 0 when no read is strobed.
- R9: An active-low asynchronous reset, asserted at any time, brings every register, count and interrupt output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 2 | Count tick level for each timer; a rising edge counts |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| match_irq_o | output | 2 | Per-timer single-cycle match pulse |

## Verification
Directed runs cover free-run wrap-around across 255, clear-and-start with a small compare value, a compare rewrite onto the current count, and 16-bit cascade runs in both modes. Together these separate an 8-bit wrap from a 16-bit carry and a clear from an increment. Ticks sent to both timers while one of them is disabled, or to timer 1 during cascade, show whether the enable and cascade bits actually gate the counting. Randomised segments mix compare values, modes, tick masks and count reads, some of which collide with a tick edge. A dropped or doubled tick then shows up as a count or interrupt-total mismatch against the bench model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_CNT0 = 0;
  localparam int unsigned ADDR_CNT1 = 1;
  localparam int unsigned ADDR_CMP0 = 2;
  localparam int unsigned ADDR_CMP1 = 3;
  localparam int unsigned ADDR_CTL0 = 4;
  localparam int unsigned ADDR_CTL1 = 5;
  localparam int unsigned ADDR_CASC = 6;

  // control byte: bit1 = clear-and-start, bit0 = enable
  typedef struct packed {
    logic clr;
    logic en;
  } tmr_ctl_t;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_tick_gate.sv
module tmr_tick_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic hold_i,
  input  logic en_i,
  output logic step_o
);
  logic tick_q;
  logic pend_q, pend_d;
  logic rise;

  assign rise   = tick_i & ~tick_q;
  assign step_o = en_i & ~hold_i & (rise | pend_q);

  always_comb begin
    if (!en_i)       pend_d = 1'b0;
    else if (hold_i) pend_d = pend_q | rise;
    else             pend_d = pend_q & rise;  // two steps pending: apply one, keep one
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      tick_q <= tick_i;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CW = 8,
  parameter int unsigned AW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [CW-1:0]       wdata_i,
  input  logic [1:0][CW-1:0]  cnt_i,
  output logic [CW-1:0]       rdata_o,
  output logic [1:0][CW-1:0]  cmp_o,
  output tmr_ctl_t [1:0]      ctl_o,
  output logic                casc_o,
  output logic                hold_o
);
  logic [1:0][CW-1:0] cmp_q, cmp_d;
  tmr_ctl_t [1:0]     ctl_q, ctl_d;
  logic               casc_q, casc_d;
  logic               reg_ld;

  assign reg_ld = wr_i;

  always_comb begin
    cmp_d  = cmp_q;
    ctl_d  = ctl_q;
    casc_d = casc_q;
    if (addr_i == AW'(ADDR_CMP0)) cmp_d[0] = wdata_i;
    if (addr_i == AW'(ADDR_CMP1)) cmp_d[1] = wdata_i;
    if (addr_i == AW'(ADDR_CTL0)) ctl_d[0] = tmr_ctl_t'(wdata_i[1:0]);
    if (addr_i == AW'(ADDR_CTL1)) ctl_d[1] = tmr_ctl_t'(wdata_i[1:0]);
    if (addr_i == AW'(ADDR_CASC)) casc_d   = wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      ctl_q  <= '0;
      casc_q <= 1'b0;
    end else if (reg_ld) begin
      cmp_q  <= cmp_d;
      ctl_q  <= ctl_d;
      casc_q <= casc_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        AW'(ADDR_CNT0): rdata_o = cnt_i[0];
        AW'(ADDR_CNT1): rdata_o = cnt_i[1];
        AW'(ADDR_CMP0): rdata_o = cmp_q[0];
        AW'(ADDR_CMP1): rdata_o = cmp_q[1];
        AW'(ADDR_CTL0): rdata_o = {{(CW-2){1'b0}}, ctl_q[0]};
        AW'(ADDR_CTL1): rdata_o = {{(CW-2){1'b0}}, ctl_q[1]};
        AW'(ADDR_CASC): rdata_o = {{(CW-1){1'b0}}, casc_q};
        default:        rdata_o = '0;
      endcase
    end
  end

  assign hold_o = rd_i & ((addr_i == AW'(ADDR_CNT0)) | (addr_i == AW'(ADDR_CNT1)));
  assign cmp_o  = cmp_q;
  assign ctl_o  = ctl_q;
  assign casc_o = casc_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         step_i,
  input  tmr_ctl_t [1:0]     ctl_i,
  input  logic               casc_i,
  input  logic [1:0][CW-1:0] cmp_i,
  output logic [1:0][CW-1:0] cnt_o,
  output logic [1:0]         irq_o
);
  localparam int unsigned WW = 2 * CW;

  logic [1:0][CW-1:0] cnt_q, cnt_d;
  logic [1:0]         irq_q, irq_d;
  logic [WW-1:0]      wide_cur, wide_cmp, wide_nxt;
  logic               cnt_ld;

  assign wide_cur = {cnt_q[1], cnt_q[0]};
  assign wide_cmp = {cmp_i[1], cmp_i[0]};
  assign cnt_ld   = (|step_i) | ~ctl_i[0].en | ~ctl_i[1].en;

  always_comb begin
    cnt_d    = cnt_q;
    irq_d    = '0;
    wide_nxt = wide_cur;
    if (casc_i) begin
      if (!ctl_i[0].en) begin
        cnt_d = '0;
      end else if (step_i[0]) begin
        if (ctl_i[0].clr && (wide_cur == wide_cmp)) wide_nxt = '0;
        else                                        wide_nxt = wide_cur + 1'b1;
        cnt_d[1] = wide_nxt[WW-1:CW];
        cnt_d[0] = wide_nxt[CW-1:0];
        if (wide_nxt == wide_cmp) irq_d = 2'b11;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (!ctl_i[i].en) begin
          cnt_d[i] = '0;
        end else if (step_i[i]) begin
          if (ctl_i[i].clr && (cnt_q[i] == cmp_i[i])) cnt_d[i] = '0;
          else                                       cnt_d[i] = cnt_q[i] + 1'b1;
          if (cnt_d[i] == cmp_i[i]) irq_d[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/dual_timer_cascade.sv
module dual_timer_cascade
  import tmr_pkg::*;
#(
  parameter int unsigned CW = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    tick_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [CW-1:0] bus_wdata_i,
  output logic [CW-1:0] bus_rdata_o,
  output logic [1:0]    match_irq_o
);
  logic               rst_sync_n;
  logic [1:0]         step_w;
  logic [1:0][CW-1:0] cnt_w;
  logic [1:0][CW-1:0] cmp_w;
  tmr_ctl_t [1:0]     ctl_w;
  logic               casc_w;
  logic               hold_w;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  for (genvar g = 0; g < 2; g++) begin : g_tick
    tmr_tick_gate u_gate (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .tick_i (tick_i[g]),
      .hold_i (hold_w),
      .en_i   (ctl_w[g].en),
      .step_o (step_w[g])
    );
  end

  tmr_regs #(.CW(CW), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_i    (bus_wr_i),
    .rd_i    (bus_rd_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .cnt_i   (cnt_w),
    .rdata_o (bus_rdata_o),
    .cmp_o   (cmp_w),
    .ctl_o   (ctl_w),
    .casc_o  (casc_w),
    .hold_o  (hold_w)
  );

  tmr_core #(.CW(CW)) u_core (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .step_i (step_w),
    .ctl_i  (ctl_w),
    .casc_i (casc_w),
    .cmp_i  (cmp_w),
    .cnt_o  (cnt_w),
    .irq_o  (match_irq_o)
  );
endmodule

// File: rtl/dual_timer_sva.sv
module dual_timer_sva #(
  parameter int unsigned CW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0][CW-1:0] cnt,
  input logic [1:0]         en,
  input logic               casc,
  input logic               hold,
  input logic [1:0]         irq
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt[0]) |-> (cnt[0] == CW'($past(cnt[0]) + 1'b1)) || (cnt[0] == '0)); // R1

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en[0] |=> cnt[0] == '0); // R2

  AST_CASC_DISABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && !en[0]) |=> cnt[1] == '0); // R2

  AST_CASC_CARRY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && en[0] && (cnt[0] != {CW{1'b1}})) |=> ($stable(cnt[1]) || cnt[1] == '0)); // R5

  AST_CASC_IRQ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    casc |=> (irq[0] == irq[1])); // R6

  AST_HOLD_FREEZE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && en[0]) |=> $stable(cnt[0])); // R7

  AST_HOLD_FREEZE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && en[1] && !casc) |=> $stable(cnt[1])); // R7
endmodule

bind dual_timer_cascade dual_timer_sva u_sva (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .cnt   (cnt_w),
  .en    ({ctl_w[1].en, ctl_w[0].en}),
  .casc  (casc_w),
  .hold  (hold_w),
  .irq   (match_irq_o)
);

// File: tb/tb_dual_timer_cascade.sv
module tb_dual_timer_cascade;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [1:0] tick;
  logic       wr, rd;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [1:0] irq;

  dual_timer_cascade dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .bus_wr_i    (wr),
    .bus_rd_i    (rd),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .match_irq_o (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int irq_seen [2];
  int exp_irq  [2];

  logic [7:0] m_cnt [2];
  logic [7:0] m_cmp [2];
  bit m_en [2], m_clr [2], m_casc;

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq[0]) irq_seen[0]++;
      if (irq[1]) irq_seen[1]++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic bus_write(input int a, input int d);
    @(negedge clk);
    wr = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output int d);
    @(negedge clk);
    rd = 1'b1; addr = 3'(a);
    #1 d = int'(rdata);
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic void model_step(input logic [1:0] mask);
    logic [15:0] w, k;
    if (m_casc) begin
      if (mask[0] && m_en[0]) begin
        w = {m_cnt[1], m_cnt[0]};
        k = {m_cmp[1], m_cmp[0]};
        if (m_clr[0] && w == k) w = '0;
        else                    w = w + 16'd1;
        m_cnt[1] = w[15:8];
        m_cnt[0] = w[7:0];
        if (w == k) begin exp_irq[0]++; exp_irq[1]++; end
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (mask[i] && m_en[i]) begin
          if (m_clr[i] && m_cnt[i] == m_cmp[i]) m_cnt[i] = '0;
          else                                  m_cnt[i] = m_cnt[i] + 8'd1;
          if (m_cnt[i] == m_cmp[i]) exp_irq[i]++;
        end
      end
    end
  endfunction

  task automatic pulse(input logic [1:0] mask);
    @(negedge clk); tick = mask;
    @(negedge clk); tick = 2'b00;
    model_step(mask);
  endtask

  task automatic pulses(input logic [1:0] mask, input int n);
    for (int p = 0; p < n; p++) pulse(mask);
  endtask

  task automatic read_during_tick(input logic [1:0] mask);
    @(negedge clk);
    tick = mask; rd = 1'b1; addr = 3'd0;
    #1 chk("R7 read value during tick", int'(rdata), int'(m_cnt[0]));
    @(negedge clk);
    tick = 2'b00; rd = 1'b0;
    model_step(mask);
  endtask

  task automatic set_ctl(input int i, input bit en, input bit clr);
    bus_write(4 + i, {clr, en});
    m_en[i] = en; m_clr[i] = clr;
    if (!en && !(m_casc && i == 1)) begin
      m_cnt[i] = '0;
      if (m_casc && i == 0) m_cnt[1] = '0;
    end
  endtask

  task automatic set_cmp(input int i, input int v);
    bus_write(2 + i, v);
    m_cmp[i] = 8'(v);
  endtask

  task automatic set_casc(input bit c);
    bus_write(6, c);
    m_casc = c;
  endtask

  task automatic check_state(input string req);
    int d;
    bus_read(0, d); chk({req, " count0"}, d, int'(m_cnt[0]));
    bus_read(1, d); chk({req, " count1"}, d, int'(m_cnt[1]));
    chk({req, " irq0 total"}, irq_seen[0], exp_irq[0]);
    chk({req, " irq1 total"}, irq_seen[1], exp_irq[1]);
  endtask

  task automatic model_clear();
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = '0; m_cmp[i] = '0; m_en[i] = 0; m_clr[i] = 0;
    end
    m_casc = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int d;
    int unsigned seed_init;
    seed_init = $urandom(32'd4711);
    tick = 2'b00; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    irq_seen[0] = 0; irq_seen[1] = 0; exp_irq[0] = 0; exp_irq[1] = 0;
    model_clear();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state of every register and the interrupt lines
    for (int a = 0; a < 7; a++) begin
      bus_read(a, d);
      chk($sformatf("R9 reset value addr %0d", a), d, 0);
    end
    chk("R9 irq after reset", int'(irq), 0);

    // R8: register readback, counts read-only, idle read data
    set_cmp(0, 8'hA5);
    bus_read(2, d); chk("R8 compare0 readback", d, 8'hA5);
    bus_write(0, 8'h55);
    bus_write(1, 8'h66);
    bus_read(0, d); chk("R8 count0 write ignored", d, 0);
    bus_read(1, d); chk("R8 count1 write ignored", d, 0);
    set_ctl(1, 0, 1);
    bus_read(5, d); chk("R8 control1 readback", d, 2);
    #1 chk("R8 idle read data", int'(rdata), 0);

    // R1: free-run wrap, timer 1 disabled
    set_cmp(0, 8'h80);
    set_ctl(0, 1, 0);
    set_ctl(1, 0, 0);
    pulses(2'b11, 260);
    check_state("R1 free-run wrap");
    chk("R1 count0 after 260 ticks", int'(m_cnt[0]), 4);
    chk("R4 one match in wrap", exp_irq[0], 1);

    // R3 and R4: clear-and-start with compare 5
    set_ctl(0, 0, 0);
    set_cmp(0, 5);
    set_ctl(0, 1, 1);
    pulses(2'b01, 14);
    check_state("R3 clear-and-start");
    chk("R3 count after 14 ticks", int'(m_cnt[0]), 2);

    // R4: compare rewritten onto current count raises nothing
    set_cmp(0, 2);
    repeat (3) @(negedge clk);
    check_state("R4 compare rewrite");

    // R7: reads colliding with tick edges lose no count
    read_during_tick(2'b01);
    read_during_tick(2'b01);
    pulse(2'b01);
    check_state("R7 pending tick applied");

    // R2: disable clears
    set_ctl(0, 0, 0);
    check_state("R2 disable clears");

    // R5: cascade free-run, timer 1 ticks and enable ignored
    set_ctl(1, 0, 0);
    set_casc(1);
    set_cmp(0, 8'hFF); set_cmp(1, 8'hFF);
    set_ctl(0, 1, 0);
    pulses(2'b01, 300);
    pulses(2'b10, 5);
    check_state("R5 cascade carry");
    chk("R5 high byte after 300 ticks", int'(m_cnt[1]), 1);

    // R2: low enable clears both bytes in cascade
    set_ctl(0, 0, 0);
    check_state("R2 cascade disable");

    // R6: 16-bit clear-and-start compare 0x0102
    set_cmp(0, 8'h02); set_cmp(1, 8'h01);
    set_ctl(0, 1, 1);
    pulses(2'b11, 600);
    check_state("R6 cascade match");
    chk("R6 two matches expected", exp_irq[1], 2);
    set_ctl(0, 0, 0);
    set_casc(0);

    // Random segments: R1 R3 R4 R7 in independent mode
    for (int it = 0; it < 30; it++) begin
      int n;
      set_ctl(0, 0, 0);
      set_ctl(1, 0, 0);
      set_cmp(0, $urandom_range(0, 255));
      set_cmp(1, $urandom_range(0, 40));
      set_ctl(0, ($urandom_range(0, 3) != 0), $urandom_range(0, 1) != 0);
      set_ctl(1, ($urandom_range(0, 3) != 0), $urandom_range(0, 1) != 0);
      n = $urandom_range(0, 150);
      for (int p = 0; p < n; p++) begin
        int r;
        logic [1:0] mask;
        r = $urandom_range(0, 9);
        mask = 2'($urandom_range(1, 3));
        if (r == 0) read_during_tick(mask);
        else if (r == 1) begin
          bus_read(1, d);
          chk("R7 count1 read", d, int'(m_cnt[1]));
        end else pulse(mask);
      end
      check_state("R1 R3 R4 random segment");
    end

    // R9: asynchronous reset mid-run
    set_ctl(0, 1, 0);
    pulses(2'b01, 7);
    @(negedge clk);
    #2 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    repeat (4) @(negedge clk);
    for (int a = 0; a < 7; a++) begin
      bus_read(a, d);
      chk($sformatf("R9 async reset addr %0d", a), d, 0);
    end

    finish_run();
  end
endmodule